// File: doc/BRIEF.md
# Clock Generator Initialization Sequencer

This controller brings a programmable clock generator from power-up to running outputs. One start strobe makes it issue a fixed, ordered chain of single-byte register writes. Each write is an address and data pair, handed to a downstream serial bus master over a request/acknowledge pair. The chain runs in this order: the outputs are switched off, the output drivers are powered down, the interrupt mask and the optional crystal load setting are written, the frequency plan is loaded, both PLLs are soft-reset, and the outputs are switched back on.

The frequency plan is a 100-byte image held in an internal byte memory. It is filled through a load port while the sequencer is idle. The sequencer splits the image over two register windows. The first 78 bytes go to registers 15 to 92 and the remaining 22 bytes go to registers 149 to 170. These image writes sit between the fixed control writes. The no-crystal bit, the interrupt mask, the capacitance code and its enable are captured when the start strobe is accepted. They are used for the whole run.

Top module: `clkseq_init_seq`

## Requirements
- R1: While reset is held, and after it is released, busy, done, error and wr_req are all low.
- R2: A start strobe while idle is accepted at that clock edge. From the next cycle, busy is high, done and error are low, and the first write requested is register 3 with data 0xFF.
- R3: The second write is register 187 with data 0xC0.
- R4: Writes 3 to 10 go to registers 16, 17, and so on up to 23 in ascending order. Each carries 0x80, or 0x84 when the no-crystal bit was high at the accepted start.
- R5: The next write is register 2, carrying the interrupt-mask byte captured at the accepted start.
- R6: When the capacitance enable was high at the accepted start, the next write is register 183 with data {cap_code, 6'b010010}, the code in bits 7:6. When the enable was low, this write is left out.
- R7: Next come 78 writes to registers 15 to 92 carrying image bytes 0 to 77. Then 22 writes go to registers 149 to 170 carrying image bytes 78 to 99.
- R8: Next comes register 177 with data 0xAC, then register 3 with data 0x00. In the cycle after this last write is acknowledged, done is high and busy is low. A full run is 113 writes, or 114 with the capacitance write.
- R9: A write completes in a cycle where wr_req and wr_ack are both high. Until then wr_req stays high and wr_addr and wr_data stay unchanged.
- R10: If wr_nack is high while a write is requested, that write and all later ones are dropped. From the next cycle, busy and done are low, error is high, and wr_req stays low.
- R11: A start strobe while busy has no effect on the order or the count of writes.
- R12: Image loads (img_we) are stored while idle and ignored while busy.
- R13: done and error keep their value until the next accepted start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe |
| no_xtal | input | 1 | Selects 0x84 instead of 0x80 for driver power-down |
| irq_mask | input | 8 | Interrupt mask byte for register 2 |
| cap_code | input | 2 | Crystal load code for bits 7:6 of register 183 |
| cap_en | input | 1 | Enables the register 183 write |
| img_we | input | 1 | Image byte load strobe |
| img_idx | input | 7 | Image byte index, 0 to 99 |
| img_data | input | 8 | Image byte value |
| wr_req | output | 1 | Write request to the bus master |
| wr_addr | output | 8 | Register address of the requested write |
| wr_data | output | 8 | Data of the requested write |
| wr_ack | input | 1 | Write accepted |
| wr_nack | input | 1 | Write refused; aborts the run |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last run completed |
| error | output | 1 | Last run aborted |

## Verification
The bench sweeps all 16 combinations of no-crystal, capacitance enable and capacitance code. The interrupt mask changes with each combination. Each combination is run with acknowledge delays from zero to three cycles. The inputs are inverted right after start, which separates values captured at start from values read live. Each logged write is compared with a sequence computed in the bench. This tells apart an omitted or extra capacitance write, a wrong driver code, a misplaced image split and a dropped final enable. Negative acknowledges at the first write, inside the driver block, inside the image and at the final enable each check the abort point and the recovery. A start strobe and an image load made mid-run show the ignored cases.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_OFF,
    PH_MISC,
    PH_DRV,
    PH_IRQ,
    PH_XCAP,
    PH_IMG_LO,
    PH_IMG_HI,
    PH_PLLRST,
    PH_ON
  } seq_phase_e;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
  } reg_wr_t;

  // fixed control register addresses
  localparam logic [7:0] A_OUT_DIS  = 8'd3;
  localparam logic [7:0] A_MISC     = 8'd187;
  localparam logic [7:0] A_DRV_BASE = 8'd16;
  localparam logic [7:0] A_IRQ_MASK = 8'd2;
  localparam logic [7:0] A_XTAL_CAP = 8'd183;
  localparam logic [7:0] A_PLAN_LO  = 8'd15;
  localparam logic [7:0] A_PLAN_HI  = 8'd149;
  localparam logic [7:0] A_PLL_RST  = 8'd177;

  // fixed control data values
  localparam logic [7:0] D_ALL_OFF       = 8'hFF;
  localparam logic [7:0] D_MISC          = 8'hC0;
  localparam logic [7:0] D_DRV_PD        = 8'h80;
  localparam logic [7:0] D_DRV_PD_NOXTAL = 8'h84;
  localparam logic [7:0] D_PLL_RST       = 8'hAC;

endpackage

// File: rtl/clkseq_rst_sync.sv
module clkseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q = pipe_q[STAGES-1];

endmodule

// File: rtl/clkseq_image_ram.sv
module clkseq_image_ram #(
  parameter int DEPTH = 100,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [7:0]       ld_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);

  logic [7:0] mem [DEPTH];
  logic       ld_ok;

  assign ld_ok = ld_en && (ld_idx < IDX_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (ld_ok) begin
      mem[ld_idx] <= ld_data;
    end
  end

  assign rd_data = (rd_idx < IDX_W'(DEPTH)) ? mem[rd_idx] : 8'h00;

endmodule

// File: rtl/clkseq_ctrl.sv
module clkseq_ctrl
  import clkseq_pkg::*;
#(
  parameter int DRV_COUNT   = 8,
  parameter int PLAN_LO_LEN = 78,
  parameter int PLAN_HI_LEN = 22,
  parameter int IDX_W       = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cap_en_q,
  input  logic             acc,
  input  logic             rej,
  output seq_phase_e       phase_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             start_acc,
  output logic             busy,
  output logic             done,
  output logic             error
);

  seq_phase_e       phase_d, phase_after;
  logic [IDX_W-1:0] idx_d, last_idx;
  logic             done_q, done_d, err_q, err_d;
  logic             step_last, step_en;

  // length of the current phase and its successor
  always_comb begin
    case (phase_q)
      PH_DRV:    last_idx = IDX_W'(DRV_COUNT - 1);
      PH_IMG_LO: last_idx = IDX_W'(PLAN_LO_LEN - 1);
      PH_IMG_HI: last_idx = IDX_W'(PLAN_HI_LEN - 1);
      default:   last_idx = '0;
    endcase
    case (phase_q)
      PH_OFF:    phase_after = PH_MISC;
      PH_MISC:   phase_after = PH_DRV;
      PH_DRV:    phase_after = PH_IRQ;
      PH_IRQ:    phase_after = cap_en_q ? PH_XCAP : PH_IMG_LO;
      PH_XCAP:   phase_after = PH_IMG_LO;
      PH_IMG_LO: phase_after = PH_IMG_HI;
      PH_IMG_HI: phase_after = PH_PLLRST;
      PH_PLLRST: phase_after = PH_ON;
      default:   phase_after = PH_IDLE;
    endcase
  end

  assign step_last = (idx_q == last_idx);
  assign start_acc = (phase_q == PH_IDLE) && start;
  assign step_en   = start_acc | rej | acc;

  // next state
  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    done_d  = done_q;
    err_d   = err_q;
    if (start_acc) begin
      phase_d = PH_OFF;
      idx_d   = '0;
      done_d  = 1'b0;
      err_d   = 1'b0;
    end else if (rej) begin
      phase_d = PH_IDLE;
      idx_d   = '0;
      err_d   = 1'b1;
    end else if (acc) begin
      if (step_last) begin
        phase_d = phase_after;
        idx_d   = '0;
        done_d  = (phase_q == PH_ON);
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (step_en) begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy  = (phase_q != PH_IDLE);
  assign done  = done_q;
  assign error = err_q;

  // R2
  start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && start) |=> (phase_q == PH_OFF && busy && !done && !error));

  // R10
  nack_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rej) |=> (!busy && error && !done));

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !acc && !rej) |=> (busy && $stable(phase_q) && $stable(idx_q)));

  // R13
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(done) && $stable(error)));

  // R6
  xcap_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IRQ && acc && !rej && !cap_en_q) |=> (phase_q == PH_IMG_LO));

endmodule

// File: rtl/clkseq_wr_map.sv
module clkseq_wr_map
  import clkseq_pkg::*;
#(
  parameter int         PLAN_LO_LEN = 78,
  parameter int         IDX_W       = 7,
  parameter logic [5:0] XCAP_LOW    = 6'h12,
  parameter logic [7:0] ENABLE_MASK = 8'h00
) (
  input  seq_phase_e       phase,
  input  logic [IDX_W-1:0] idx,
  input  logic             no_xtal_q,
  input  logic [7:0]       irq_q,
  input  logic [1:0]       cap_q,
  input  logic [7:0]       img_byte,
  output logic [IDX_W-1:0] img_rd_idx,
  output reg_wr_t          wr
);

  always_comb begin
    img_rd_idx = idx;
    wr.addr    = 8'h00;
    wr.data    = 8'h00;
    case (phase)
      PH_OFF: begin
        wr.addr = A_OUT_DIS;
        wr.data = D_ALL_OFF;
      end
      PH_MISC: begin
        wr.addr = A_MISC;
        wr.data = D_MISC;
      end
      PH_DRV: begin
        wr.addr = A_DRV_BASE + 8'(idx);
        wr.data = no_xtal_q ? D_DRV_PD_NOXTAL : D_DRV_PD;
      end
      PH_IRQ: begin
        wr.addr = A_IRQ_MASK;
        wr.data = irq_q;
      end
      PH_XCAP: begin
        wr.addr = A_XTAL_CAP;
        wr.data = {cap_q, XCAP_LOW};
      end
      PH_IMG_LO: begin
        wr.addr = A_PLAN_LO + 8'(idx);
        wr.data = img_byte;
      end
      PH_IMG_HI: begin
        img_rd_idx = idx + IDX_W'(PLAN_LO_LEN);
        wr.addr    = A_PLAN_HI + 8'(idx);
        wr.data    = img_byte;
      end
      PH_PLLRST: begin
        wr.addr = A_PLL_RST;
        wr.data = D_PLL_RST;
      end
      PH_ON: begin
        wr.addr = A_OUT_DIS;
        wr.data = ENABLE_MASK;
      end
      default: begin
        wr.addr = 8'h00;
        wr.data = 8'h00;
      end
    endcase
  end

endmodule

// File: rtl/clkseq_init_seq.sv
module clkseq_init_seq
  import clkseq_pkg::*;
#(
  parameter int         DRV_COUNT   = 8,
  parameter int         PLAN_LO_LEN = 78,
  parameter int         PLAN_HI_LEN = 22,
  parameter logic [5:0] XCAP_LOW    = 6'h12,
  parameter logic [7:0] ENABLE_MASK = 8'h00,
  localparam int        PLAN_LEN    = PLAN_LO_LEN + PLAN_HI_LEN,
  localparam int        IDX_W       = $clog2(PLAN_LEN + DRV_COUNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             no_xtal,
  input  logic [7:0]       irq_mask,
  input  logic [1:0]       cap_code,
  input  logic             cap_en,
  input  logic             img_we,
  input  logic [IDX_W-1:0] img_idx,
  input  logic [7:0]       img_data,
  output logic             wr_req,
  output logic [7:0]       wr_addr,
  output logic [7:0]       wr_data,
  input  logic             wr_ack,
  input  logic             wr_nack,
  output logic             busy,
  output logic             done,
  output logic             error
);

  logic             rst_q;
  seq_phase_e       phase;
  logic [IDX_W-1:0] idx, rd_idx;
  logic             start_acc, acc, rej, ld_en;
  logic [7:0]       rd_byte;
  reg_wr_t          cur_wr;

  // captured run configuration
  logic             no_xtal_q, cap_en_q;
  logic [7:0]       irq_q;
  logic [1:0]       cap_q;

  clkseq_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  assign acc   = wr_req && wr_ack && !wr_nack;
  assign rej   = wr_req && wr_nack;
  assign ld_en = img_we && !busy;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      no_xtal_q <= 1'b0;
      cap_en_q  <= 1'b0;
      irq_q     <= 8'h00;
      cap_q     <= 2'b00;
    end else if (start_acc) begin
      no_xtal_q <= no_xtal;
      cap_en_q  <= cap_en;
      irq_q     <= irq_mask;
      cap_q     <= cap_code;
    end
  end

  clkseq_ctrl #(
    .DRV_COUNT   (DRV_COUNT),
    .PLAN_LO_LEN (PLAN_LO_LEN),
    .PLAN_HI_LEN (PLAN_HI_LEN),
    .IDX_W       (IDX_W)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_q),
    .start     (start),
    .cap_en_q  (cap_en_q),
    .acc       (acc),
    .rej       (rej),
    .phase_q   (phase),
    .idx_q     (idx),
    .start_acc (start_acc),
    .busy      (busy),
    .done      (done),
    .error     (error)
  );

  clkseq_image_ram #(
    .DEPTH (PLAN_LEN),
    .IDX_W (IDX_W)
  ) i_ram (
    .clk     (clk),
    .ld_en   (ld_en),
    .ld_idx  (img_idx),
    .ld_data (img_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_byte)
  );

  clkseq_wr_map #(
    .PLAN_LO_LEN (PLAN_LO_LEN),
    .IDX_W       (IDX_W),
    .XCAP_LOW    (XCAP_LOW),
    .ENABLE_MASK (ENABLE_MASK)
  ) i_map (
    .phase      (phase),
    .idx        (idx),
    .no_xtal_q  (no_xtal_q),
    .irq_q      (irq_q),
    .cap_q      (cap_q),
    .img_byte   (rd_byte),
    .img_rd_idx (rd_idx),
    .wr         (cur_wr)
  );

  assign wr_req  = busy;
  assign wr_addr = cur_wr.addr;
  assign wr_data = cur_wr.data;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_req && !wr_ack && !wr_nack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  // R8
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_q)
    done |-> (!busy && !error));

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (error && !start) |=> !wr_req);

endmodule

// File: tb/test_clkseq_init_seq.sv
module test_clkseq_init_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, no_xtal, cap_en, img_we, wr_ack, wr_nack;
  logic [7:0] irq_mask, img_data;
  logic [1:0] cap_code;
  logic [6:0] img_idx;
  logic       wr_req, busy, done, error;
  logic [7:0] wr_addr, wr_data;

  always #5 clk = ~clk;

  clkseq_init_seq i_clkseq_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .no_xtal(no_xtal),
    .irq_mask(irq_mask), .cap_code(cap_code), .cap_en(cap_en),
    .img_we(img_we), .img_idx(img_idx), .img_data(img_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack(wr_ack), .wr_nack(wr_nack),
    .busy(busy), .done(done), .error(error)
  );

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] img [100];
  logic [7:0] lg_addr [128];
  logic [7:0] lg_data [128];
  int wcnt, nack_at, dly_mode, unstable;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus master model: acknowledges after a pattern-driven delay
  initial begin : responder
    logic [7:0] cap_a, cap_d;
    bit have;
    int waited;
    have = 0;
    waited = 0;
    wr_ack = 1'b0;
    wr_nack = 1'b0;
    forever begin
      @(negedge clk);
      if (wr_ack || wr_nack) begin
        if (wr_ack && wcnt < 128) begin
          lg_addr[wcnt] = cap_a;
          lg_data[wcnt] = cap_d;
        end
        if (wr_ack) wcnt++;
        wr_ack = 1'b0;
        wr_nack = 1'b0;
        have = 0;
        waited = 0;
      end
      if (wr_req) begin
        if (!have) begin
          cap_a = wr_addr;
          cap_d = wr_data;
          have = 1;
        end else if (wr_addr != cap_a || wr_data != cap_d) begin
          unstable++;
        end
        if (waited >= ((dly_mode == 0) ? 0 : (wcnt * 5 + dly_mode) % 4)) begin
          if (wcnt == nack_at) wr_nack = 1'b1;
          else wr_ack = 1'b1;
        end else begin
          waited++;
        end
      end
    end
  end

  task automatic expect_wr(input int n, input bit nx, input bit ce, input logic [1:0] cc,
                           input logic [7:0] irq, output logic [7:0] a,
                           output logic [7:0] d, output string tag);
    int off, m;
    off = ce ? 12 : 11;
    if (n == 0) begin a = 8'd3; d = 8'hFF; tag = "R2"; end
    else if (n == 1) begin a = 8'd187; d = 8'hC0; tag = "R3"; end
    else if (n <= 9) begin a = 8'(14 + n); d = nx ? 8'h84 : 8'h80; tag = "R4"; end
    else if (n == 10) begin a = 8'd2; d = irq; tag = "R5"; end
    else if (ce && n == 11) begin a = 8'd183; d = {cc, 6'b010010}; tag = "R6"; end
    else begin
      m = n - off;
      if (m < 78) begin a = 8'(15 + m); d = img[m]; tag = "R7"; end
      else if (m < 100) begin a = 8'(149 + m - 78); d = img[m]; tag = "R7"; end
      else if (m == 100) begin a = 8'd177; d = 8'hAC; tag = "R8"; end
      else begin a = 8'd3; d = 8'h00; tag = "R8"; end
    end
  endtask

  task automatic load_image(input int seed);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      img[i] = 8'((i * 37 + seed) & 255);
      img_we = 1'b1;
      img_idx = 7'(i);
      img_data = img[i];
    end
    @(negedge clk);
    img_we = 1'b0;
  endtask

  task automatic run_seq(input bit nx, input bit ce, input logic [1:0] cc,
                         input logic [7:0] irq, input int mode, input int nack_pos,
                         input bit poke);
    int total, cyc;
    logic [7:0] ea, ed;
    string tag;
    wcnt = 0;
    unstable = 0;
    nack_at = nack_pos;
    dly_mode = mode;
    @(negedge clk);
    no_xtal = nx; cap_en = ce; cap_code = cc; irq_mask = irq; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    // inverted inputs after start: only captured values may be used
    no_xtal = ~nx; cap_en = ~ce; cap_code = ~cc; irq_mask = ~irq;
    check(busy && !done && !error, "R2", "busy/done/error after start",
          {busy, done, error}, 3'b100);
    cyc = 0;
    while (busy && cyc < 3000) begin
      @(negedge clk); #1;
      cyc++;
      if (poke && cyc == 20) begin
        start = 1'b1; img_we = 1'b1; img_idx = 7'd3; img_data = ~img[3];
      end else if (poke && cyc == 21) begin
        start = 1'b0; img_we = 1'b0;
      end
    end
    start = 1'b0; img_we = 1'b0;
    total = (nack_pos >= 0) ? nack_pos : (ce ? 114 : 113);
    check(wcnt == total, (nack_pos >= 0) ? "R10" : (poke ? "R11" : "R8"),
          "write count", wcnt, total);
    for (int n = 0; n < total && n < wcnt; n++) begin
      expect_wr(n, nx, ce, cc, irq, ea, ed, tag);
      check(lg_addr[n] == ea && lg_data[n] == ed, tag, $sformatf("write %0d addr/data", n),
            {lg_addr[n], lg_data[n]}, {ea, ed});
    end
    check(unstable == 0, "R9", "request changed while waiting", unstable, 0);
    if (nack_pos >= 0) begin
      check(error && !done && !busy, "R10", "flags after nack", {busy, done, error}, 3'b001);
    end else begin
      check(done && !error && !busy, "R8", "flags after final ack", {busy, done, error}, 3'b010);
    end
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); #1;
      if (wr_req) unstable++;
    end
    check(unstable == 0, "R10", "no request while idle", unstable, 0);
    check(done == (nack_pos < 0) && error == (nack_pos >= 0), "R13", "flags held while idle",
          {done, error}, {(nack_pos < 0), (nack_pos >= 0)});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(0, "WDOG", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; start = 1'b0; no_xtal = 1'b0; cap_en = 1'b0; cap_code = 2'b00;
    irq_mask = 8'h00; img_we = 1'b0; img_idx = '0; img_data = 8'h00;
    wcnt = 0; nack_at = -1; dly_mode = 0; unstable = 0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !error && !wr_req, "R1", "outputs in reset",
          {busy, done, error, wr_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && !error && !wr_req, "R1", "outputs after reset release",
          {busy, done, error, wr_req}, 0);
    load_image(11);
    for (int k = 0; k < 16; k++) begin
      run_seq(k[0], k[1], 2'(k >> 2), 8'(k * 29 + 3), k % 4, -1, k == 5);
      if (k == 6) begin
        // image byte 3 was poked during run 5 while busy
        check(lg_data[(k[1] ? 12 : 11) + 3] == img[3], "R12", "image load while busy ignored",
              lg_data[(k[1] ? 12 : 11) + 3], img[3]);
      end
    end
    load_image(90);
    run_seq(1'b0, 1'b1, 2'b01, 8'hA5, 2, -1, 1'b0);
    check(lg_data[12 + 40] == img[40], "R12", "image load while idle stored",
          lg_data[52], img[40]);
    run_seq(1'b0, 1'b0, 2'b00, 8'h11, 0, 0, 1'b0);
    run_seq(1'b1, 1'b0, 2'b00, 8'h22, 1, 5, 1'b0);
    run_seq(1'b0, 1'b1, 2'b11, 8'h33, 3, 60, 1'b0);
    run_seq(1'b0, 1'b0, 2'b10, 8'h44, 2, 112, 1'b0);
    run_seq(1'b1, 1'b1, 2'b10, 8'h55, 1, -1, 1'b0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule